// File: doc/BRIEF.md
# Hierarchical MSR Routing Hub

This block is one node in a chain of interconnect hubs that carry 64-bit model-specific-register reads and writes between modules. A request enters on the upstream port with a 32-bit address. The upper 18 bits form a routing path made of six 3-bit channel fields. The lower 14 bits form a register index. The hub reads the leftmost channel field and then removes it by shifting the routing path left by three bits, filling with zeros. Channel 0 selects the hub's own small register bank. Channels 1 to 7 select one of seven downstream module ports, and the hub forwards the rewritten address on the chosen port. Because each hop consumes one field, routing depends on the source: the same target has a different address from each starting point. Up to six hubs can be chained.

Every request and response channel uses valid/ready. A sender raises valid and holds valid and payload unchanged until the cycle in which ready is also high. That cycle is the transfer. The hub keeps one transaction in flight. It accepts no new request until the requester has taken the response for the current one. A per-port presence mask, driven as a plain control input, marks which downstream ports are connected. A request to an absent port ends with an error response, and nothing is sent downstream.

Top module: `msr_route_hub`

## Requirements
- R1: After reset, the hub is ready for a request (`up_req_ready`=1). No response is valid, and no downstream request is valid.
- R2: A request whose address bits [31:29] hold channel p, with p from 1 to 7 and the port present, is forwarded only on downstream port p (bit p-1 of the port vectors). That port's response comes back to the requester.
- R3: The forwarded address is the incoming routing field [31:14] shifted left by three bits with zero fill. The 14-bit index [13:0] is passed on unchanged.
- R4: The write flag and the 64-bit write data are forwarded unchanged with a forwarded request.
- R5: Channel 0 accesses the hub's own bank. Indices 1 to NREG-1 are 64-bit read/write registers that reset to zero. A read returns the stored value, and a write response carries zero data.
- R6: Own-bank index 0 is read-only. A read returns the presence mask zero-extended, and writes to it are discarded.
- R7: Own-bank indices NREG and above complete without error. Writes to them are discarded and reads return zero.
- R8: A request to a channel whose presence bit is 0 returns an error response with zero data. The response is valid in the cycle after the request is accepted, and no downstream valid is raised.
- R9: The read data and error bit of a downstream response are returned to the requester unchanged.
- R10: From the acceptance of a request until its response has been transferred, `up_req_ready` is 0.
- R11: While a valid output (downstream request or upstream response) is not yet accepted, that valid and its payload stay stable.
- R12: With two hubs chained through port 2 of the first hub, an address with leading fields 2.q reaches port q of the second hub with the routing field shifted by six bits. With leading fields 2.0 it reaches the second hub's own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_present | input | 7 | Bit p-1 set means downstream port p is connected |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Hub can accept a request |
| up_req_addr | input | 32 | Routing path [31:14] and register index [13:0] |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_wdata | input | 64 | Write data |
| up_rsp_valid | output | 1 | Response valid |
| up_rsp_ready | input | 1 | Requester takes the response |
| up_rsp_rdata | output | 64 | Read data |
| up_rsp_err | output | 1 | Access fault |
| dn_req_valid | output | 7 | Per-port request valid, at most one bit set |
| dn_req_ready | input | 7 | Per-port request ready |
| dn_req_addr | output | 32 | Rewritten address, shared by all ports |
| dn_req_write | output | 1 | Forwarded write flag |
| dn_req_wdata | output | 64 | Forwarded write data |
| dn_rsp_valid | input | 7 | Per-port response valid |
| dn_rsp_ready | output | 7 | Per-port response ready |
| dn_rsp_rdata | input | 448 | Per-port read data, port p in slice p-1 |
| dn_rsp_err | input | 7 | Per-port error flag |

## Verification
The bench builds two hubs with the default parameters (3-bit channels, seven ports, four own-bank entries) and connects port 2 of the first hub to the upstream side of the second. Each remaining port drives a responder that stalls its request ready and tags its data with the port number. With this setup, every pair of the first two channel fields can be swept under two presence masks. The sweep reaches both own banks, absent ports at either hop, relayed errors and two-hop address shifts. Response back-pressure is applied for up to two cycles on each transaction.

// File: rtl/msr_route_pkg.sv
package msr_route_pkg;
  localparam int unsigned DEF_DATA_W = 64;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_IDX_W  = 14;
  localparam int unsigned DEF_CH_W   = 3;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_FWD  = 2'd1,
    HS_WAIT = 2'd2,
    HS_RSP  = 2'd3
  } hub_state_e;
endpackage

// File: rtl/msr_addr_shift.sv
module msr_addr_shift #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 14,
  parameter int unsigned CH_W   = 3
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [CH_W-1:0]   chan,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int unsigned ROUTE_W = ADDR_W - IDX_W;

  logic [ROUTE_W-1:0] route;

  assign route    = addr_in[ADDR_W-1 -: ROUTE_W];
  assign chan     = route[ROUTE_W-1 -: CH_W];
  // leading field consumed; zeros enter at the far end, index untouched
  assign addr_out = {route[ROUTE_W-CH_W-1:0], {CH_W{1'b0}}, addr_in[IDX_W-1:0]};
endmodule

// File: rtl/msr_self_regs.sv
module msr_self_regs #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 14,
  parameter int unsigned NREG   = 4,
  parameter int unsigned NPORT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [NPORT-1:0]  present,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] bank [NREG];

  assign bank[0] = DATA_W'(present);

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank[i] <= '0;
      end else if (acc_en && acc_write && (acc_idx == IDX_W'(i))) begin
        bank[i] <= acc_wdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (acc_idx == IDX_W'(i)) rd_data = bank[i];
    end
  end

  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_idx == '0 && !acc_write) |-> (rd_data == DATA_W'(present))); // R6
endmodule

// File: rtl/msr_rsp_select.sv
module msr_rsp_select #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NPORT  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        sel,
  input  logic [NPORT*DATA_W-1:0] rdata_all,
  input  logic [NPORT-1:0]        err_all,
  output logic [DATA_W-1:0]       rdata,
  output logic                    err
);
  always_comb begin
    rdata = '0;
    err   = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (sel[i]) begin
        rdata = rdata | rdata_all[i*DATA_W +: DATA_W];
        err   = err | err_all[i];
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel)); // R9
endmodule

// File: rtl/msr_route_hub.sv
module msr_route_hub
  import msr_route_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  parameter int unsigned CH_W   = DEF_CH_W,
  parameter int unsigned NPORT  = (1 << DEF_CH_W) - 1,
  parameter int unsigned NREG   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        port_present,
  input  logic                    up_req_valid,
  output logic                    up_req_ready,
  input  logic [ADDR_W-1:0]       up_req_addr,
  input  logic                    up_req_write,
  input  logic [DATA_W-1:0]       up_req_wdata,
  output logic                    up_rsp_valid,
  input  logic                    up_rsp_ready,
  output logic [DATA_W-1:0]       up_rsp_rdata,
  output logic                    up_rsp_err,
  output logic [NPORT-1:0]        dn_req_valid,
  input  logic [NPORT-1:0]        dn_req_ready,
  output logic [ADDR_W-1:0]       dn_req_addr,
  output logic                    dn_req_write,
  output logic [DATA_W-1:0]       dn_req_wdata,
  input  logic [NPORT-1:0]        dn_rsp_valid,
  output logic [NPORT-1:0]        dn_rsp_ready,
  input  logic [NPORT*DATA_W-1:0] dn_rsp_rdata,
  input  logic [NPORT-1:0]        dn_rsp_err
);
  hub_state_e state;

  logic [CH_W-1:0]   in_chan;
  logic [CH_W-1:0]   in_chan_m1;
  logic [ADDR_W-1:0] in_next;
  logic              accept;
  logic              self_hit;
  logic              port_ok;
  logic [DATA_W-1:0] self_rd;
  logic [DATA_W-1:0] sel_rdata;
  logic              sel_err;

  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;
  logic [DATA_W-1:0] cur_wdata;
  logic [NPORT-1:0]  cur_port;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_err;

  msr_addr_shift #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_shift (
    .addr_in (up_req_addr),
    .chan    (in_chan),
    .addr_out(in_next)
  );

  assign in_chan_m1 = in_chan - CH_W'(1);
  assign accept     = up_req_valid && (state == HS_IDLE);
  assign self_hit   = accept && (in_chan == '0);
  assign port_ok    = (in_chan != '0) && port_present[in_chan_m1];

  msr_self_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NREG(NREG), .NPORT(NPORT)) u_self (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (self_hit),
    .acc_write(up_req_write),
    .acc_idx  (up_req_addr[IDX_W-1:0]),
    .acc_wdata(up_req_wdata),
    .present  (port_present),
    .rd_data  (self_rd)
  );

  msr_rsp_select #(.DATA_W(DATA_W), .NPORT(NPORT)) u_rsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (dn_rsp_ready),
    .rdata_all(dn_rsp_rdata),
    .err_all  (dn_rsp_err),
    .rdata    (sel_rdata),
    .err      (sel_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= HS_IDLE;
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_wdata <= '0;
      cur_port  <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (state)
        HS_IDLE: begin
          if (accept) begin
            if (in_chan == '0) begin
              rsp_data <= up_req_write ? '0 : self_rd;
              rsp_err  <= 1'b0;
              state    <= HS_RSP;
            end else if (port_ok) begin
              cur_addr  <= in_next;
              cur_write <= up_req_write;
              cur_wdata <= up_req_wdata;
              cur_port  <= NPORT'(1) << in_chan_m1;
              state     <= HS_FWD;
            end else begin
              rsp_data <= '0;
              rsp_err  <= 1'b1;
              state    <= HS_RSP;
            end
          end
        end
        HS_FWD: begin
          if (|(dn_req_valid & dn_req_ready)) state <= HS_WAIT;
        end
        HS_WAIT: begin
          if (|(dn_rsp_valid & dn_rsp_ready)) begin
            rsp_data <= sel_rdata;
            rsp_err  <= sel_err;
            state    <= HS_RSP;
          end
        end
        HS_RSP: begin
          if (up_rsp_ready) begin
            cur_port <= '0;
            state    <= HS_IDLE;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  assign up_req_ready = (state == HS_IDLE);
  assign up_rsp_valid = (state == HS_RSP);
  assign up_rsp_rdata = rsp_data;
  assign up_rsp_err   = rsp_err;
  assign dn_req_valid = (state == HS_FWD)  ? cur_port : '0;
  assign dn_rsp_ready = (state == HS_WAIT) ? cur_port : '0;
  assign dn_req_addr  = cur_addr;
  assign dn_req_write = cur_write;
  assign dn_req_wdata = cur_wdata;

  AST_DN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dn_req_valid)); // R2
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_req_valid && !(|(dn_req_valid & dn_req_ready))) |=>
      ($stable(dn_req_valid) && $stable(dn_req_addr) && $stable(dn_req_wdata) && $stable(dn_req_write))); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_rdata) && $stable(up_rsp_err))); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid || |dn_req_valid || |dn_rsp_ready) |-> !up_req_ready); // R10
  AST_ABSENT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready && up_req_addr[ADDR_W-1 -: CH_W] != '0 &&
     !port_present[up_req_addr[ADDR_W-1 -: CH_W] - CH_W'(1)]) |=>
      (up_rsp_valid && up_rsp_err && dn_req_valid == '0)); // R8
endmodule

// File: tb/msr_route_hub_tb.sv
module msr_route_hub_leaf #(
  parameter logic [31:0] TAG = 32'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] addr,
  input  logic        write,
  input  logic [63:0] wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rdata,
  output logic        err
);
  logic [1:0] wait_cnt;
  assign req_ready = req_valid && !rsp_valid && (wait_cnt == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt  <= '0;
      rsp_valid <= 1'b0;
      rdata     <= '0;
      err       <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        wait_cnt  <= '0;
        rsp_valid <= 1'b1;
        rdata     <= write ? (wdata ^ {TAG, addr}) : {TAG, addr};
        err       <= (addr[13:0] == 14'h3FFF);
      end else begin
        if (req_valid && !rsp_valid) wait_cnt <= wait_cnt + 2'd1;
        if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      end
    end
  end
endmodule

module msr_route_hub_tb;
  localparam int NP = 7;
  localparam int DW = 64;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [NP-1:0] pres_a, pres_b;
  logic          up_req_valid, up_req_write, up_rsp_ready;
  logic [31:0]   up_req_addr;
  logic [63:0]   up_req_wdata;
  logic          up_req_ready, up_rsp_valid, up_rsp_err;
  logic [63:0]   up_rsp_rdata;

  logic [NP-1:0]    a_dv, a_dr, a_rv, a_rr, a_re;
  logic [31:0]      a_da;
  logic             a_dwr;
  logic [63:0]      a_dwd;
  logic [NP*DW-1:0] a_rd;

  logic [NP-1:0]    b_dv, b_dr, b_rv, b_rr, b_re;
  logic [31:0]      b_da;
  logic             b_dwr;
  logic [63:0]      b_dwd;
  logic [NP*DW-1:0] b_rd;

  logic        b_up_ready, b_up_rsp_valid, b_up_rsp_err;
  logic [63:0] b_up_rsp_rdata;

  msr_route_hub u_dut (
    .clk(clk), .rst_n(rst_n), .port_present(pres_a),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_addr(up_req_addr),
    .up_req_write(up_req_write), .up_req_wdata(up_req_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err),
    .dn_req_valid(a_dv), .dn_req_ready(a_dr), .dn_req_addr(a_da),
    .dn_req_write(a_dwr), .dn_req_wdata(a_dwd),
    .dn_rsp_valid(a_rv), .dn_rsp_ready(a_rr), .dn_rsp_rdata(a_rd), .dn_rsp_err(a_re)
  );

  msr_route_hub u_hop (
    .clk(clk), .rst_n(rst_n), .port_present(pres_b),
    .up_req_valid(a_dv[1]), .up_req_ready(b_up_ready), .up_req_addr(a_da),
    .up_req_write(a_dwr), .up_req_wdata(a_dwd),
    .up_rsp_valid(b_up_rsp_valid), .up_rsp_ready(a_rr[1]),
    .up_rsp_rdata(b_up_rsp_rdata), .up_rsp_err(b_up_rsp_err),
    .dn_req_valid(b_dv), .dn_req_ready(b_dr), .dn_req_addr(b_da),
    .dn_req_write(b_dwr), .dn_req_wdata(b_dwd),
    .dn_rsp_valid(b_rv), .dn_rsp_ready(b_rr), .dn_rsp_rdata(b_rd), .dn_rsp_err(b_re)
  );

  for (genvar p = 0; p < NP; p++) begin : g_ports
    if (p == 1) begin : g_link
      assign a_dr[p]            = b_up_ready;
      assign a_rv[p]            = b_up_rsp_valid;
      assign a_rd[p*DW +: DW]   = b_up_rsp_rdata;
      assign a_re[p]            = b_up_rsp_err;
    end else begin : g_leaf_a
      msr_route_hub_leaf #(.TAG(32'(p + 1))) u_leaf (
        .clk(clk), .rst_n(rst_n), .req_valid(a_dv[p]), .req_ready(a_dr[p]),
        .addr(a_da), .write(a_dwr), .wdata(a_dwd),
        .rsp_valid(a_rv[p]), .rsp_ready(a_rr[p]), .rdata(a_rd[p*DW +: DW]), .err(a_re[p])
      );
    end
    msr_route_hub_leaf #(.TAG(32'(p + 9))) u_leaf_b (
      .clk(clk), .rst_n(rst_n), .req_valid(b_dv[p]), .req_ready(b_dr[p]),
      .addr(b_da), .write(b_dwr), .wdata(b_dwd),
      .rsp_valid(b_rv[p]), .rsp_ready(b_rr[p]), .rdata(b_rd[p*DW +: DW]), .err(b_re[p])
    );
  end

  logic [63:0] a_reg [NR];
  logic [63:0] b_reg [NR];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hop(input logic [31:0] a);
    logic [17:0] r;
    r   = a[31:14];
    hop = {r[14:0], 3'b000, a[13:0]};
  endfunction

  function automatic logic [31:0] mk(input int f0, input int f1, input int mid, input int idx);
    mk = {3'(f0), 3'(f1), 12'(mid), 14'(idx)};
  endfunction

  task automatic run_case(input logic [31:0] a, input bit w, input logic [63:0] wd, input int stall);
    logic [63:0] ed, rd, rd2;
    logic        ee, e, e2, busy;
    bit          absent;
    int          lat;
    string       rq;
    int          f0, f1, idx;
    logic [31:0] a1, a2;
    f0 = int'(a[31:29]); f1 = int'(a[28:26]); idx = int'(a[13:0]);
    a1 = hop(a); a2 = hop(a1);
    absent = 1'b0; ed = '0; ee = 1'b0;
    rq = (idx == 0) ? "R6" : (idx < NR) ? "R5" : "R7";
    if (f0 == 0) begin
      if (w) begin
        if (idx >= 1 && idx < NR) a_reg[idx] = wd;
      end else ed = (idx == 0) ? 64'(pres_a) : (idx < NR) ? a_reg[idx] : 64'd0;
    end else if (!pres_a[f0-1]) begin
      absent = 1'b1; ee = 1'b1; rq = "R8";
    end else if (f0 != 2) begin
      ed = w ? (wd ^ {32'(f0), a1}) : {32'(f0), a1};
      ee = (idx == 14'h3FFF);
      rq = ee ? "R9" : (w ? "R4" : "R3");
    end else if (f1 == 0) begin
      rq = "R12";
      if (w) begin
        if (idx >= 1 && idx < NR) b_reg[idx] = wd;
      end else ed = (idx == 0) ? 64'(pres_b) : (idx < NR) ? b_reg[idx] : 64'd0;
    end else if (!pres_b[f1-1]) begin
      ee = 1'b1; rq = "R12";
    end else begin
      ed = w ? (wd ^ {32'(8 + f1), a2}) : {32'(8 + f1), a2};
      ee = (idx == 14'h3FFF);
      rq = "R12";
    end

    @(negedge clk);
    up_req_valid = 1'b1; up_req_addr = a; up_req_write = w; up_req_wdata = wd;
    while (!up_req_ready) @(negedge clk);
    @(negedge clk);
    up_req_valid = 1'b0;
    lat = 1;
    while (!up_rsp_valid) begin @(negedge clk); lat++; end
    rd = up_rsp_rdata; e = up_rsp_err; busy = up_req_ready;
    repeat (stall) @(negedge clk);
    rd2 = up_rsp_rdata; e2 = up_rsp_err;
    up_rsp_ready = 1'b1;
    @(negedge clk);
    up_rsp_ready = 1'b0;

    chk(rd == ed, rq, rd, ed);
    chk(e == ee, rq, 64'(e), 64'(ee));
    chk(!busy, "R10", 64'(busy), 64'd0);
    if (absent) chk(lat == 1, "R8", 64'(lat), 64'd1);
    if (stall > 0) chk(rd2 == rd && e2 == e, "R11", rd2, rd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin a_reg[i] = '0; b_reg[i] = '0; end
    pres_a = 7'h7F; pres_b = 7'h7F;
    up_req_valid = 1'b0; up_req_write = 1'b0; up_req_addr = '0; up_req_wdata = '0;
    up_rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(up_req_ready == 1'b1, "R1", 64'(up_req_ready), 64'd1);
    chk(up_rsp_valid == 1'b0, "R1", 64'(up_rsp_valid), 64'd0);
    chk(a_dv == '0 && b_dv == '0, "R1", 64'({a_dv, b_dv}), 64'd0);

    // sweep the first two channel fields under two presence masks (R2 R3 R4 R8 R9 R12)
    for (int m = 0; m < 2; m++) begin
      pres_a = (m == 0) ? 7'h7F : 7'b1101111;
      pres_b = (m == 0) ? 7'h7F : 7'b0111111;
      for (int f0 = 0; f0 < 8; f0++) begin
        for (int f1 = 0; f1 < 8; f1++) begin
          int idx;
          idx = (f1 == 7) ? 16383 : ((f0 * 5) << 3) + f1;
          run_case(mk(f0, f1, f0 * 345 + f1 * 77 + m, idx), (f1 % 3) == 1,
                   {16'hA5C3, 16'(f0 * 8 + f1), 32'(m * 1000 + f1)}, (f0 + f1) % 3);
        end
      end
    end

    // own bank of the first hub: R5 R6 R7
    run_case(mk(0, 0, 0, 2), 1'b1, 64'h0123_4567_89AB_CDEF, 0);
    run_case(mk(0, 5, 9, 2), 1'b0, '0, 1);
    run_case(mk(0, 0, 0, 0), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run_case(mk(0, 0, 0, 0), 1'b0, '0, 0);
    run_case(mk(0, 0, 0, 9), 1'b1, 64'hDEAD_BEEF_0000_1111, 0);
    run_case(mk(0, 0, 0, 9), 1'b0, '0, 2);
    // own bank of the second hub reached through 2.0 (R12); first hub's entry 3 untouched
    run_case(mk(2, 0, 0, 3), 1'b1, 64'h5555_AAAA_1234_0000, 0);
    run_case(mk(2, 0, 7, 3), 1'b0, '0, 0);
    run_case(mk(0, 0, 0, 3), 1'b0, '0, 0);
    // two-hop route 2.3 with deeper fields set (R12 R3)
    run_case({3'd2, 3'd3, 3'd5, 3'd1, 3'd6, 3'd4, 14'h0ABC}, 1'b0, '0, 1);
    // absent port at the first hop (R8)
    pres_a = 7'b1111011;
    run_case(mk(3, 1, 0, 5), 1'b1, 64'h1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule